// File: doc/BRIEF.md
# Clock Power-Down and Output-Gating Controller

This block sits beside the clock synthesizers of a platform clock generator. For every clock output it decides whether the clock runs, is parked low, or floats. Differential outputs are never floated: when parked, the true side is pulled low and the complement is driven low. Single-ended outputs float while the device is powered down. The decision depends on four things: one combined power-good / power-down pin, a per-output enable bit, a sticky management-mode bit, and a restore-policy bit.

The first time power-good is seen, the block captures three strap pins into latches:

- the CPU frequency select;
- the 120/100 MHz display select;
- the SATA/SRC1 select.

It then holds every output parked for a programmable stabilization window before releasing the outputs.

When the pin falls later, the block enters power-down. If management mode is set, it enters a low-power management state instead. On exit, the restore policy decides between two paths:

- keep the configuration and only wait out the stabilization window again;
- wipe every configuration bit back to its cold-boot value and reopen the strap latches.

The sticky management bit forces the keep path. In the management low-power state, output 0 (the CPU pair) keeps running when its own enable bit is set.

Output gating is glitch-free. Each gate changes only in a cycle in which the gated clock is reported low.

Top module: `ckg_pwr_ctrl`

## Requirements
- R1: After reset all outputs are stopped (`out_run` = 0). Single-ended outputs float (`out_hiz` = 1 at indices `N_DIFF` and above). Differential outputs are parked low (`out_hiz` = 0). The latched strap outputs read 0.
- R2: On the first power-good, the strap pins are copied to `lat_fsel` (0 = 133.33 MHz CPU, 1 = 100 MHz), `lat_disp_n` (0 = 120 MHz display clock, 1 = 100 MHz) and `lat_sata_n` (0 = SATA, 1 = SRC1). The latches then ignore the strap pins.
- R3: After power-good is seen, every output stays stopped and driven for `STAB_CYC` cycles. Enabled outputs start running exactly `STAB_CYC`+4 clock edges after `pwrgd_pd_n` rises; the first of those edges is the one that samples the rise.
- R4: In the running state, output i runs when enable bit i is 1. It is parked low and driven when the bit is 0.
- R5: Every per-output enable bit is 1 after reset and after a configuration wipe. The restore bit is 1 and the M1 enable bit is 0 at those times.
- R6: Four clock edges after `pwrgd_pd_n` falls (not three), outside management mode, every output stops and the single-ended outputs float.
- R7: With the restore bit at 1, leaving power-down keeps the enables and the strap latches, waits `STAB_CYC` cycles, then resumes the same outputs.
- R8: With the restore bit at 0 and management mode off, leaving power-down does three things. It wipes the configuration to its R5 values, re-samples the strap pins, and starts the outputs `STAB_CYC`+5 edges after the rise.
- R9: Once written to 1, the management-mode bit stays 1 when 0 is written; only reset clears it.
- R10: While management mode is set, the restore bit is treated as 1. Leaving power-down never wipes the configuration or re-samples the straps.
- R11: In management mode, power-down enters the M1 state. In M1, output 0 runs only when both its enable bit and the M1 enable bit are 1. All other outputs are parked as in R6.
- R12: A gate (`out_run` or `out_hiz`) of output i changes only on an edge at which `clk_lvl[i]` is 0. While `clk_lvl[i]` is 1, it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_pd_n | input | 1 | Power-good when high, power-down request when low (asynchronous) |
| strap_fsel | input | 1 | CPU frequency strap pin |
| strap_disp_n | input | 1 | Display 120/100 MHz strap pin |
| strap_sata_n | input | 1 | SATA/SRC1 strap pin |
| cfg_we | input | 1 | Write strobe for the configuration fields below |
| cfg_oe | input | N_DIFF+N_SE | Per-output enable values to write |
| cfg_restore | input | 1 | Restore-policy value to write |
| cfg_mgmt | input | 1 | Management-mode value to write (sticky at 1) |
| cfg_m1_en | input | 1 | Output-0 M1 enable value to write |
| clk_lvl | input | N_DIFF+N_SE | Current level of each gated clock |
| out_run | output | N_DIFF+N_SE | Gate: output i toggles when 1 |
| out_hiz | output | N_DIFF+N_SE | Gate: output i floats when 1 (single-ended only) |
| lat_fsel | output | 1 | Latched CPU frequency select |
| lat_disp_n | output | 1 | Latched display select |
| lat_sata_n | output | 1 | Latched SATA/SRC1 select |

## Verification
A wrong sequencer state shows up at the gates within one or two edges. Outputs may run early during the stabilization window, or fail to stop on the fourth edge of a power-down. A wrong counter limit moves the first running edge by exactly the error. A lost sticky bit or a wrongly applied restore policy stays hidden until the next power-down exit. It then appears as enables jumping back to all ones and as freshly re-sampled strap latches on the first running cycle. A gate cell that ignores the clock level shows up on the first configuration change made while that clock is high.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    typedef enum logic [2:0] {
        ST_LATCH_OPEN = 3'd0,
        ST_STAB       = 3'd1,
        ST_RUN        = 3'd2,
        ST_PDOWN      = 3'd3,
        ST_M1         = 3'd4
    } ckg_state_t;

endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ckg_cfg_regs.sv
module ckg_cfg_regs #(
    parameter int N_OUT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_OUT-1:0] wr_oe,
    input  logic             wr_restore,
    input  logic             wr_mgmt,
    input  logic             wr_m1_en,
    input  logic             wipe,
    output logic [N_OUT-1:0] oe_q,
    output logic             restore_q,
    output logic             mgmt_q,
    output logic             m1_en_q
);

    localparam logic [N_OUT-1:0] OE_COLD = {N_OUT{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q      <= OE_COLD;
            restore_q <= 1'b1;
            mgmt_q    <= 1'b0;
            m1_en_q   <= 1'b0;
        end else if (wipe) begin
            // wipe only occurs with management mode off, so mgmt_q is already 0
            oe_q      <= OE_COLD;
            restore_q <= 1'b1;
            mgmt_q    <= 1'b0;
            m1_en_q   <= 1'b0;
        end else if (wr_en) begin
            oe_q      <= wr_oe;
            restore_q <= wr_restore;
            mgmt_q    <= mgmt_q | wr_mgmt;
            m1_en_q   <= wr_m1_en;
        end
    end

endmodule

// File: rtl/ckg_gate_cell.sv
module ckg_gate_cell #(
    parameter bit IS_SE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic run_req,
    input  logic hiz_req,
    output logic run,
    output logic hiz
);

    localparam logic HIZ_RST = IS_SE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            hiz <= HIZ_RST;
        end else if (!lvl) begin
            run <= run_req;
            hiz <= hiz_req & HIZ_RST;
        end
    end

endmodule

// File: rtl/ckg_seq.sv
module ckg_seq
    import ckg_pkg::*;
#(
    parameter int N_OUT    = 6,
    parameter int N_DIFF   = 5,
    parameter int STAB_CYC = 25773
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    input  logic             strap_fsel,
    input  logic             strap_disp_n,
    input  logic             strap_sata_n,
    input  logic [N_OUT-1:0] oe,
    input  logic             restore,
    input  logic             mgmt,
    input  logic             m1_en,
    output logic [N_OUT-1:0] run_req,
    output logic [N_OUT-1:0] hiz_req,
    output logic             wipe,
    output logic             lat_fsel,
    output logic             lat_disp_n,
    output logic             lat_sata_n,
    output logic             live
);

    localparam int CW = (STAB_CYC > 2) ? $clog2(STAB_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STAB_CYC - 1);
    localparam logic [N_OUT-1:0] DIFF_MASK = {N_OUT{1'b1}} >> (N_OUT - N_DIFF);
    localparam logic [N_OUT-1:0] SE_MASK   = ~DIFF_MASK;

    ckg_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          stab_done;
    logic          keep_cfg;

    assign stab_done = (cnt_q == CNT_LAST);
    assign keep_cfg  = restore | mgmt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LATCH_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LATCH_OPEN: begin
                if (pwr_ok) state_d = ST_STAB;
            end
            ST_STAB: begin
                if (!pwr_ok)        state_d = mgmt ? ST_M1 : ST_PDOWN;
                else if (stab_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!pwr_ok) state_d = mgmt ? ST_M1 : ST_PDOWN;
            end
            ST_PDOWN, ST_M1: begin
                if (pwr_ok) state_d = keep_cfg ? ST_STAB : ST_LATCH_OPEN;
            end
            default: state_d = ST_LATCH_OPEN;
        endcase
    end

    assign wipe = ((state_q == ST_PDOWN) || (state_q == ST_M1)) && pwr_ok && !keep_cfg;

    // stabilization window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != ST_STAB) begin
            cnt_q <= '0;
        end else if (!stab_done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // strap latches, open only in the latches-open state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_fsel   <= 1'b0;
            lat_disp_n <= 1'b0;
            lat_sata_n <= 1'b0;
        end else if ((state_q == ST_LATCH_OPEN) && pwr_ok) begin
            lat_fsel   <= strap_fsel;
            lat_disp_n <= strap_disp_n;
            lat_sata_n <= strap_sata_n;
        end
    end

    // gate requests
    always_comb begin
        run_req = '0;
        hiz_req = SE_MASK;
        live    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                run_req = oe;
                hiz_req = '0;
                live    = 1'b1;
            end
            ST_M1: begin
                run_req[0] = oe[0] & m1_en;
                live       = 1'b1;
            end
            ST_STAB: begin
                hiz_req = '0;
            end
            ST_LATCH_OPEN, ST_PDOWN: begin
                hiz_req = SE_MASK;
            end
            default: begin
                hiz_req = SE_MASK;
            end
        endcase
    end

endmodule

// File: rtl/ckg_pwr_ctrl.sv
module ckg_pwr_ctrl #(
    parameter int N_DIFF      = 5,
    parameter int N_SE        = 1,
    parameter int STAB_CYC    = 25773,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwrgd_pd_n,
    input  logic                     strap_fsel,
    input  logic                     strap_disp_n,
    input  logic                     strap_sata_n,
    input  logic                     cfg_we,
    input  logic [N_DIFF+N_SE-1:0]   cfg_oe,
    input  logic                     cfg_restore,
    input  logic                     cfg_mgmt,
    input  logic                     cfg_m1_en,
    input  logic [N_DIFF+N_SE-1:0]   clk_lvl,
    output logic [N_DIFF+N_SE-1:0]   out_run,
    output logic [N_DIFF+N_SE-1:0]   out_hiz,
    output logic                     lat_fsel,
    output logic                     lat_disp_n,
    output logic                     lat_sata_n
);

    localparam int N_OUT = N_DIFF + N_SE;

    logic             pwr_ok;
    logic [N_OUT-1:0] oe_q;
    logic             restore_q, mgmt_q, m1_en_q;
    logic             wipe;
    logic [N_OUT-1:0] run_req, hiz_req;
    logic             st_live;

    ckg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwrgd_pd_n),
        .q     (pwr_ok)
    );

    ckg_cfg_regs #(.N_OUT(N_OUT)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_oe      (cfg_oe),
        .wr_restore (cfg_restore),
        .wr_mgmt    (cfg_mgmt),
        .wr_m1_en   (cfg_m1_en),
        .wipe       (wipe),
        .oe_q       (oe_q),
        .restore_q  (restore_q),
        .mgmt_q     (mgmt_q),
        .m1_en_q    (m1_en_q)
    );

    ckg_seq #(.N_OUT(N_OUT), .N_DIFF(N_DIFF), .STAB_CYC(STAB_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_ok       (pwr_ok),
        .strap_fsel   (strap_fsel),
        .strap_disp_n (strap_disp_n),
        .strap_sata_n (strap_sata_n),
        .oe           (oe_q),
        .restore      (restore_q),
        .mgmt         (mgmt_q),
        .m1_en        (m1_en_q),
        .run_req      (run_req),
        .hiz_req      (hiz_req),
        .wipe         (wipe),
        .lat_fsel     (lat_fsel),
        .lat_disp_n   (lat_disp_n),
        .lat_sata_n   (lat_sata_n),
        .live         (st_live)
    );

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_gate
        ckg_gate_cell #(.IS_SE(gi >= N_DIFF)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (clk_lvl[gi]),
            .run_req (run_req[gi]),
            .hiz_req (hiz_req[gi]),
            .run     (out_run[gi]),
            .hiz     (out_hiz[gi])
        );
    end

endmodule

// File: rtl/ckg_pwr_ctrl_chk.sv
module ckg_pwr_ctrl_chk #(
    parameter int N_OUT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_ok,
    input logic [N_OUT-1:0] clk_lvl,
    input logic [N_OUT-1:0] out_run,
    input logic [N_OUT-1:0] out_hiz,
    input logic             mgmt_q,
    input logic [N_OUT-1:0] oe_q,
    input logic             cfg_we,
    input logic             st_live
);

    // R12
    gate_run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_run ^ $past(out_run)) & $past(clk_lvl)) == '0);

    // R12
    gate_hiz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_hiz ^ $past(out_hiz)) & $past(clk_lvl)) == '0);

    // R9
    mgmt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mgmt_q) |-> mgmt_q);

    // R10
    mgmt_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mgmt_q) && !$past(cfg_we)) |-> (oe_q == $past(oe_q)));

    // R6
    pd_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pwr_ok, 2) && ($past(clk_lvl) == '0)) |-> (out_run[N_OUT-1:1] == '0));

    // R3
    run_only_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clk_lvl) == '0) && (out_run != '0)) |-> $past(st_live));

endmodule

bind ckg_pwr_ctrl ckg_pwr_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_ok  (pwr_ok),
    .clk_lvl (clk_lvl),
    .out_run (out_run),
    .out_hiz (out_hiz),
    .mgmt_q  (mgmt_q),
    .oe_q    (oe_q),
    .cfg_we  (cfg_we),
    .st_live (st_live)
);

// File: tb/tb_ckg_pwr_ctrl.sv
module tb_ckg_pwr_ctrl;

    localparam int ND   = 5;
    localparam int NS   = 1;
    localparam int N    = ND + NS;
    localparam int STAB = 16;
    localparam logic [N-1:0] SE_M = {N{1'b1}} << ND;
    localparam logic [N-1:0] ALL1 = {N{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwrgd_pd_n = 1'b0;
    logic         strap_fsel = 1'b0, strap_disp_n = 1'b0, strap_sata_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [N-1:0] cfg_oe = '0;
    logic         cfg_restore = 1'b0, cfg_mgmt = 1'b0, cfg_m1_en = 1'b0;
    logic [N-1:0] clk_lvl = '0;
    logic [N-1:0] out_run, out_hiz;
    logic         lat_fsel, lat_disp_n, lat_sata_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N-1:0] oe_m;
    logic         rest_m, mgmt_m, m1_m;
    logic [2:0]   lat_m;

    always #2 clk = ~clk;

    ckg_pwr_ctrl #(.N_DIFF(ND), .N_SE(NS), .STAB_CYC(STAB)) dut (
        .clk(clk), .rst_n(rst_n), .pwrgd_pd_n(pwrgd_pd_n),
        .strap_fsel(strap_fsel), .strap_disp_n(strap_disp_n), .strap_sata_n(strap_sata_n),
        .cfg_we(cfg_we), .cfg_oe(cfg_oe), .cfg_restore(cfg_restore),
        .cfg_mgmt(cfg_mgmt), .cfg_m1_en(cfg_m1_en), .clk_lvl(clk_lvl),
        .out_run(out_run), .out_hiz(out_hiz),
        .lat_fsel(lat_fsel), .lat_disp_n(lat_disp_n), .lat_sata_n(lat_sata_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_pd_run(input logic mg, input logic [N-1:0] oe, input logic m1);
        logic [N-1:0] r;
        r = '0;
        if (mg) r[0] = oe[0] & m1;
        return r;
    endfunction

    function automatic logic [2:0] straps_now();
        return {strap_fsel, strap_disp_n, strap_sata_n};
    endfunction

    task automatic wr(input logic [N-1:0] oe, input logic rs, input logic mg, input logic m1);
        cfg_we = 1'b1; cfg_oe = oe; cfg_restore = rs; cfg_mgmt = mg; cfg_m1_en = m1;
        tick(1);
        cfg_we = 1'b0;
        oe_m = oe; rest_m = rs; mgmt_m = mgmt_m | mg; m1_m = m1;
        tick(3);
    endtask

    task automatic enter_pd(input string req);
        pwrgd_pd_n = 1'b0;
        tick(6);
        chk(req, 32'(out_run), 32'(exp_pd_run(mgmt_m, oe_m, m1_m)));
        chk(req, 32'(out_hiz), 32'(SE_M));
    endtask

    task automatic leave_pd(input string req);
        pwrgd_pd_n = 1'b1;
        if (rest_m | mgmt_m) begin
            tick(STAB + 4);
        end else begin
            tick(STAB + 5);
            oe_m = ALL1; rest_m = 1'b1; m1_m = 1'b0;
            lat_m = straps_now();
        end
        chk(req, 32'(out_run), 32'(oe_m));
        chk(req, 32'({lat_fsel, lat_disp_n, lat_sata_n}), 32'(lat_m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] prev, pat, lvl;
        void'($urandom(32'h5EED_0042));
        oe_m = ALL1; rest_m = 1'b1; mgmt_m = 1'b0; m1_m = 1'b0; lat_m = '0;
        tick(3);
        // R1: reset state
        chk("R1 run", 32'(out_run), 0);
        chk("R1 hiz", 32'(out_hiz), 32'(SE_M));
        chk("R1 straps", 32'({lat_fsel, lat_disp_n, lat_sata_n}), 0);
        rst_n = 1'b1;
        tick(2);

        // R2/R3: first power-good, exact stabilization window
        strap_fsel = 1'b1; strap_disp_n = 1'b0; strap_sata_n = 1'b1;
        pwrgd_pd_n = 1'b1;
        tick(STAB + 3);
        chk("R3 still parked", 32'(out_run), 0);
        chk("R3 driven in window", 32'(out_hiz), 0);
        tick(1);
        chk("R3 R5 run after window", 32'(out_run), 32'(ALL1));
        lat_m = 3'b101;
        chk("R2 latched straps", 32'({lat_fsel, lat_disp_n, lat_sata_n}), 32'(lat_m));
        strap_fsel = 1'b0; strap_disp_n = 1'b1; strap_sata_n = 1'b0;
        tick(5);
        chk("R2 strap pins ignored", 32'({lat_fsel, lat_disp_n, lat_sata_n}), 32'(lat_m));

        // R4/R12: random enables with some clocks held high
        for (int k = 0; k < 24; k++) begin
            pat = N'($urandom);
            lvl = N'($urandom) & N'($urandom);
            prev = out_run;
            clk_lvl = lvl;
            wr(pat, 1'b1, 1'b0, 1'b0);
            chk("R12 gate holds while high", 32'(out_run), 32'((prev & lvl) | (pat & ~lvl)));
            clk_lvl = '0;
            tick(2);
            chk("R4 run follows enable", 32'(out_run), 32'(pat));
            chk("R4 no float while running", 32'(out_hiz), 0);
        end

        // R6 exact latency and R7 restore path
        wr(N'(6'b101101), 1'b1, 1'b0, 1'b0);
        pwrgd_pd_n = 1'b0;
        tick(3);
        chk("R6 not yet parked", 32'(out_run), 32'(oe_m));
        tick(1);
        chk("R6 parked", 32'(out_run), 0);
        chk("R6 single-ended float", 32'(out_hiz), 32'(SE_M));
        strap_fsel = 1'b0; strap_disp_n = 1'b0; strap_sata_n = 1'b0;
        tick(3);
        leave_pd("R7 restore keeps config");

        // R8: wipe path, exact timing
        wr(N'(6'b010010), 1'b0, 1'b0, 1'b1);
        enter_pd("R6 power-down");
        strap_fsel = 1'b1; strap_disp_n = 1'b1; strap_sata_n = 1'b0;
        pwrgd_pd_n = 1'b1;
        tick(STAB + 4);
        chk("R8 still parked", 32'(out_run), 0);
        tick(1);
        chk("R8 R5 enables back to defaults", 32'(out_run), 32'(ALL1));
        chk("R8 straps resampled", 32'({lat_fsel, lat_disp_n, lat_sata_n}), 32'(3'b110));
        oe_m = ALL1; rest_m = 1'b1; m1_m = 1'b0; lat_m = 3'b110;

        // R9/R10/R11: sticky management mode
        wr(N'(6'b110011), 1'b0, 1'b1, 1'b1);
        wr(N'(6'b110011), 1'b0, 1'b0, 1'b1);
        strap_fsel = 1'b0; strap_disp_n = 1'b0; strap_sata_n = 1'b1;
        enter_pd("R9 R11 M1 keeps output 0");
        leave_pd("R10 restore forced");

        wr(ALL1, 1'b0, 1'b0, 1'b0);
        enter_pd("R11 M1 enable off parks output 0");
        leave_pd("R10 restore forced");

        for (int k = 0; k < 6; k++) begin
            wr(N'($urandom), 1'b0, 1'b0, 1'($urandom));
            enter_pd("R11 random M1");
            leave_pd("R10 random exit");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule